// File: doc/BRIEF.md
# In-Band Loopback Code Detector

This block listens to a recovered T1 bit stream and reports when either of the two repeating loopback request codes is arriving. A loop-up request is the five-bit pattern 00001 sent over and over. A loop-down request is the three-bit pattern 001 sent over and over. Each request has its own sticky flag. The bits arrive on a bit clock, and a valid strobe qualifies each one. The detector does not look for the pattern at a fixed phase. Instead it compares every accepted bit with the bit that was accepted one pattern period earlier. It counts those disagreements over a long integration window, and it also counts the ones in the same window. A clean stream with the code's period and ones density gives few disagreements, even with a framing bit inserted every 193 bits and about one bit error in a hundred.

With the default window of 74,112 accepted bits, each window lasts about 48 ms at 1.544 Mbit/s. Software decides how long a code must stay present before it acts. Software also drives the separate remote-loopback control. The detector only raises the two flags and an interrupt request. Each flag has an enable for the interrupt, and one strobe clears both flags.

Top module: `loopcode_detect`

## Requirements
- R1: When a window of accepted bits is the repeating pattern 00001 (at any rotation), `up_flag` becomes 1 at the clock edge that accepts the window's last bit, and `dn_flag` stays 0.
- R2: When a window of accepted bits is the repeating pattern 001 (at any rotation), `dn_flag` becomes 1 at the clock edge that accepts the window's last bit, and `up_flag` stays 0.
- R3: Windows are back-to-back runs of WIN_LEN accepted bits, counted from reset. Only a bit with `bit_valid`=1 is counted, and `bit_data` is ignored while `bit_valid`=0. Flags can become 1 only at the edge that accepts a window's last bit.
- R4: A code with period P is declared when two conditions hold at the end of a window. The count of accepted bits that differ from the bit accepted P bits earlier must be below ERR_LIM. The count of ones must lie strictly within ERR_LIM of WIN_LEN/P. A stream with about 1% bit errors is still declared. A stream with 10% bit errors is not.
- R5: A stream that carries one framing bit per 193 bits, inserted without advancing the code, is still declared.
- R6: A window of all zeros, all ones, or the complements 110 or 11110 sets neither flag.
- R7: Flags are sticky. A flag stays 1 until `stat_clr` is sampled high, and then it reads 0 after that edge. When a declaration and `stat_clr` fall on the same edge, the declaration wins.
- R8: `irq` is 1 exactly when (`up_flag` AND `up_irq_en`) OR (`dn_flag` AND `dn_irq_en`). An enable value of 1 enables the interrupt and 0 masks it.
- R9: After reset, both flags and `irq` are 0, and the window count starts at zero.
- R10: The two flags are independent. Once both codes have been declared, both flags read 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Qualifies `bit_data` in this cycle |
| bit_data | input | 1 | Recovered line bit |
| stat_clr | input | 1 | Clears both flags |
| up_irq_en | input | 1 | 1 enables the interrupt from the loop-up flag |
| dn_irq_en | input | 1 | 1 enables the interrupt from the loop-down flag |
| up_flag | output | 1 | Sticky loop-up code indication |
| dn_flag | output | 1 | Sticky loop-down code indication |
| irq | output | 1 | Interrupt request |

## Verification
Any fault in the window counter, the period history or the two tallies appears only at a window boundary. There it shows up as a missing or extra flag, so the bench always samples one cycle before and one cycle after the last bit of each window. A fault in the flag register shows up on the very next edge after a clear or a declaration. A fault in the interrupt gating shows up at once, because `irq` is combinational from the flags and the enables.

// File: rtl/loopcode_pkg.sv
package loopcode_pkg;

  typedef enum logic [0:0] {
    CODE_UP = 1'b0,
    CODE_DN = 1'b1
  } code_e;

  localparam int CODE_NUM = 2;

  // repeat length of each code: index 0 = loop-up (00001), index 1 = loop-down (001)
  function automatic int code_period(input int idx);
    return (idx == 0) ? 5 : 3;
  endfunction

endpackage

// File: rtl/loopcode_window.sv
module loopcode_window #(
  parameter int unsigned WIN_LEN = 74112,
  parameter int unsigned CW      = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  output logic win_last
);

  localparam logic [CW-1:0] LAST_C = CW'(WIN_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign win_last = (cnt_q == LAST_C);

  always_comb begin
    cnt_d = cnt_q;
    if (bit_valid) begin
      if (win_last) cnt_d = '0;
      else          cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (bit_valid) cnt_q <= cnt_d;
  end

  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_C); // R3
  AST_WIN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && win_last |=> cnt_q == '0); // R3
  AST_WIN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(cnt_q)); // R3

endmodule

// File: rtl/loopcode_period_cmp.sv
module loopcode_period_cmp #(
  parameter int unsigned PERIOD  = 5,
  parameter int unsigned WIN_LEN = 74112,
  parameter int unsigned ERR_LIM = 2964,
  parameter int unsigned CW      = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_data,
  input  logic win_last,
  output logic hit
);

  localparam logic [CW-1:0] EXP_C = CW'(WIN_LEN / PERIOD);
  localparam logic [CW-1:0] LIM_C = CW'(ERR_LIM);

  logic [PERIOD-1:0] hist_q;
  logic [PERIOD-1:0] hist_d;
  logic [CW-1:0]     mis_q, mis_d, mis_tot;
  logic [CW-1:0]     one_q, one_d, one_tot;
  logic              mism;
  logic              mis_ok, band_lo, band_hi;

  // compare the incoming bit with the one accepted PERIOD bits ago
  assign mism    = bit_data ^ hist_q[PERIOD-1];
  assign mis_tot = mis_q + CW'(mism);
  assign one_tot = one_q + CW'(bit_data);
  assign mis_ok  = (mis_tot < LIM_C);
  assign band_lo = ((one_tot + LIM_C) > EXP_C);
  assign band_hi = (one_tot < (EXP_C + LIM_C));
  assign hit     = bit_valid & win_last & mis_ok & band_lo & band_hi;

  always_comb begin
    hist_d = {hist_q[PERIOD-2:0], bit_data};
    if (win_last) begin
      mis_d = '0;
      one_d = '0;
    end else begin
      mis_d = mis_tot;
      one_d = one_tot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      mis_q  <= '0;
      one_q  <= '0;
    end else if (bit_valid) begin
      hist_q <= hist_d;
      mis_q  <= mis_d;
      one_q  <= one_d;
    end
  end

  AST_TALLY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && win_last |=> mis_q == '0 && one_q == '0); // R3
  AST_TALLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(mis_q) && $stable(one_q) && $stable(hist_q)); // R3
  AST_MIS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid && !win_last |=> mis_q - $past(mis_q) <= CW'(1)); // R4

endmodule

// File: rtl/loopcode_flags.sv
module loopcode_flags #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flag,
  output logic         irq
);

  logic [N-1:0] flag_q;
  logic [N-1:0] flag_d;

  always_comb begin
    flag_d = (flag_q & {N{~clr}}) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  assign flag = flag_q;
  assign irq  = |(flag_q & en);

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      flag_q[i] && !clr |=> flag_q[i]); // R7
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      hit[i] |=> flag_q[i]); // R7
    AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr && !hit[i] |=> !flag_q[i]); // R7
    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_q[i] && !hit[i] |=> !flag_q[i]); // R3
  end

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    en == '0 |-> !irq); // R8

endmodule

// File: rtl/loopcode_detect.sv
module loopcode_detect #(
  parameter int unsigned WIN_LEN = 74112,
  parameter int unsigned ERR_LIM = WIN_LEN / 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  input  logic bit_data,
  input  logic stat_clr,
  input  logic up_irq_en,
  input  logic dn_irq_en,
  output logic up_flag,
  output logic dn_flag,
  output logic irq
);
  import loopcode_pkg::*;

  localparam int unsigned CW = $clog2(WIN_LEN + ERR_LIM + 1) + 1;

  logic                win_last;
  logic [CODE_NUM-1:0] hit;
  logic [CODE_NUM-1:0] en;
  logic [CODE_NUM-1:0] flag;

  loopcode_window #(
    .WIN_LEN (WIN_LEN),
    .CW      (CW)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .win_last  (win_last)
  );

  for (genvar g = 0; g < CODE_NUM; g++) begin : g_code
    loopcode_period_cmp #(
      .PERIOD  (code_period(g)),
      .WIN_LEN (WIN_LEN),
      .ERR_LIM (ERR_LIM),
      .CW      (CW)
    ) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_valid (bit_valid),
      .bit_data  (bit_data),
      .win_last  (win_last),
      .hit       (hit[g])
    );
  end

  assign en[CODE_UP] = up_irq_en;
  assign en[CODE_DN] = dn_irq_en;

  loopcode_flags #(
    .N (CODE_NUM)
  ) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (hit),
    .clr   (stat_clr),
    .en    (en),
    .flag  (flag),
    .irq   (irq)
  );

  assign up_flag = flag[CODE_UP];
  assign dn_flag = flag[CODE_DN];

  AST_FLAG_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_valid && win_last) && !up_flag && !dn_flag |=> !up_flag && !dn_flag); // R3

endmodule

// File: tb/loopcode_detect_test.sv
module loopcode_detect_test;

  localparam int WIN = 600;
  localparam int LIM = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic stat_clr = 1'b0;
  logic up_irq_en = 1'b0;
  logic dn_irq_en = 1'b0;
  logic up_flag, dn_flag, irq;

  int checks = 0;
  int errors = 0;
  int pat_pos = 0;

  always #10 clk = ~clk;

  loopcode_detect #(.WIN_LEN(WIN), .ERR_LIM(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
    .stat_clr(stat_clr), .up_irq_en(up_irq_en), .dn_irq_en(dn_irq_en),
    .up_flag(up_flag), .dn_flag(dn_flag), .irq(irq)
  );

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bit_valid = 1'b0; stat_clr = 1'b0; bit_data = 1'b0;
    up_irq_en = 1'b0; dn_irq_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic send_bit(input logic b, input logic clr);
    @(negedge clk);
    bit_valid = 1'b1; bit_data = b; stat_clr = clr;
  endtask

  task automatic idle();
    @(negedge clk);
    bit_valid = 1'b0; bit_data = 1'b0; stat_clr = 1'b0;
  endtask

  // repeating code of period per (one 1 per period), optional inversion,
  // periodic bit errors, framing-bit insertion and valid gaps
  task automatic stream(input int per, input int n, input logic inv, input int err_every,
                        input int frm_every, input int gap_every, input logic clr_last);
    for (int i = 0; i < n; i++) begin
      logic b;
      if (gap_every > 0 && (i % gap_every) == gap_every - 1) begin
        @(negedge clk);
        bit_valid = 1'b0; bit_data = ~bit_data; stat_clr = 1'b0;
      end
      if (frm_every > 0 && (i % frm_every) == frm_every - 1) begin
        b = 1'b1;
      end else begin
        b = ((pat_pos % per) == per - 1) ^ inv;
        pat_pos++;
      end
      if (err_every > 0 && (i % err_every) == err_every - 1) b = ~b;
      send_bit(b, clr_last && (i == n - 1));
    end
  endtask

  task automatic send_const(input logic v, input int n);
    for (int i = 0; i < n; i++) send_bit(v, 1'b0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(up_flag, 1'b0, "R9 up_flag after reset");
    chk(dn_flag, 1'b0, "R9 dn_flag after reset");
    chk(irq, 1'b0, "R9 irq after reset");
  endtask

  task automatic t_up_clean();
    do_reset();
    pat_pos = 2;
    stream(5, WIN - 1, 1'b0, 0, 0, 0, 1'b0);
    idle();
    chk(up_flag, 1'b0, "R3 up_flag one bit before window end");
    stream(5, 1, 1'b0, 0, 0, 0, 1'b0);
    idle();
    chk(up_flag, 1'b1, "R1 up_flag after clean loop-up window");
    chk(dn_flag, 1'b0, "R1 dn_flag during loop-up");
    chk(irq, 1'b0, "R8 irq masked");
    up_irq_en = 1'b1;
    #1;
    chk(irq, 1'b1, "R8 irq enabled by up_irq_en");
  endtask

  task automatic t_dn_errors();
    do_reset();
    pat_pos = 1;
    stream(3, WIN, 1'b0, 100, 0, 0, 1'b0);
    idle();
    chk(dn_flag, 1'b1, "R2 R4 dn_flag with 1% errors");
    chk(up_flag, 1'b0, "R2 up_flag during loop-down");
  endtask

  task automatic t_framed();
    do_reset();
    pat_pos = 0;
    stream(5, WIN, 1'b0, 0, 193, 0, 1'b0);
    idle();
    chk(up_flag, 1'b1, "R5 up_flag with framing bits");
  endtask

  task automatic t_reject();
    do_reset();
    send_const(1'b0, WIN);
    idle();
    chk(up_flag | dn_flag, 1'b0, "R6 all zeros rejected");
    send_const(1'b1, WIN);
    idle();
    chk(up_flag | dn_flag, 1'b0, "R6 all ones rejected");
    pat_pos = 0;
    stream(3, WIN, 1'b1, 0, 0, 0, 1'b0);
    idle();
    chk(up_flag | dn_flag, 1'b0, "R6 pattern 110 rejected");
    pat_pos = 0;
    stream(5, WIN, 1'b1, 0, 0, 0, 1'b0);
    idle();
    chk(up_flag | dn_flag, 1'b0, "R6 pattern 11110 rejected");
    pat_pos = 0;
    stream(3, WIN, 1'b0, 10, 0, 0, 1'b0);
    idle();
    chk(dn_flag, 1'b0, "R4 loop-down with 10% errors rejected");
  endtask

  task automatic t_sticky();
    do_reset();
    pat_pos = 0;
    stream(5, WIN, 1'b0, 0, 0, 0, 1'b0);
    idle();
    chk(up_flag, 1'b1, "R7 up_flag set");
    send_const(1'b0, WIN);
    idle();
    chk(up_flag, 1'b1, "R7 up_flag held through idle window");
    @(negedge clk);
    stat_clr = 1'b1;
    @(negedge clk);
    stat_clr = 1'b0;
    chk(up_flag, 1'b0, "R7 up_flag cleared by stat_clr");
    pat_pos = 0;
    stream(5, WIN, 1'b0, 0, 0, 0, 1'b1);
    idle();
    chk(up_flag, 1'b1, "R7 declaration wins over clear");
  endtask

  task automatic t_gaps();
    do_reset();
    pat_pos = 1;
    stream(5, WIN, 1'b0, 0, 0, 7, 1'b0);
    idle();
    chk(up_flag, 1'b1, "R3 up_flag with valid gaps and junk data");
    chk(dn_flag, 1'b0, "R3 dn_flag with valid gaps");
  endtask

  task automatic t_irq_both();
    do_reset();
    pat_pos = 0;
    stream(3, WIN, 1'b0, 0, 0, 0, 1'b0);
    idle();
    up_irq_en = 1'b1; dn_irq_en = 1'b0;
    #1;
    chk(irq, 1'b0, "R8 dn flag masked");
    dn_irq_en = 1'b1;
    #1;
    chk(irq, 1'b1, "R8 dn flag enabled");
    pat_pos = 0;
    stream(5, WIN, 1'b0, 0, 0, 0, 1'b0);
    idle();
    chk(up_flag, 1'b1, "R10 up_flag after second code");
    chk(dn_flag, 1'b1, "R10 dn_flag kept");
  endtask

  initial begin
    #3000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_up_clean();
    t_dn_errors();
    t_framed();
    t_reject();
    t_sticky();
    t_gaps();
    t_irq_both();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule